// File: doc/BRIEF.md
# Multi-channel timestamp capture FIFO

This block keeps a free-running cycle counter and, whenever one of four capture channels sees a rising edge on its routed input, stores the current count together with the channel's index in a first-in first-out buffer. Software drains the buffer with a read strobe and sees words in the order the edges arrived. Each capture channel picks its source from a wider set of inputs and can be switched on or off on its own.

The counter can be brought back to zero in two ways: by a software strobe or by an external zeroing pulse. Zeroing also empties the buffer and clears the overflow flag. A software strobe additionally emits a short pulse on a dedicated output. Wiring that output to the external zeroing input of a second unit zeroes both counters within a cable delay of each other, so their stamps stay comparable. At the nominal 20 MHz count clock one count is 50 ns. Any choice between a local and an external count clock is made outside, and the block sees a single clock.

Top module: `tsc_capture`

## Requirements
- R1: After reset or zeroing the count starts at 0 and steps by one per clock. After the value CNT_MAX (default 0x3FFFFFFF) it returns to 0.
- R2: Capture channel k (k = 0..3) takes its source from sig_in[route_sel[3k+2:3k]] (default 8 inputs, 3-bit select) and is active only while chan_en[k] is 1. A rising edge is a cycle in which the routed input is 1 after being 0 in the previous cycle. A disabled channel stores nothing.
- R3: A stored word carries the channel index k in bits 31:30 and, in bits 29:0, the count value present during the cycle in which the edge was seen.
- R4: Words are read back in order of arrival. Edges seen in the same cycle are stored in ascending channel index, and all of them carry the same count.
- R5: rd_data shows the oldest word while the buffer holds data, and shows 0 when it is empty. A cycle with rd_en high and the buffer not empty removes that word at the clock edge. rd_en while the buffer is empty has no effect.
- R6: The buffer holds 64 words. fifo_full is 1 at 64 words and fifo_empty is 1 at 0 words. A slot freed by a read becomes usable for a capture from the next cycle on.
- R7: An edge that finds no free slot is dropped, and overflow is set. Edges of the same cycle that do fit are kept in ascending channel order. overflow stays set until the next zeroing.
- R8: sw_zero high at a clock edge makes the count 0, empties the buffer and clears overflow. Edges seen in that cycle are not stored.
- R9: ext_zero_in high at a clock edge has the same effect as sw_zero.
- R10: zero_out is high for exactly the 2 cycles that follow each cycle with sw_zero high. ext_zero_in alone never drives zero_out.
- R11: After reset the count is 0, the buffer is empty, overflow is 0 and zero_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | N_IN | Candidate capture inputs |
| route_sel | input | 4*log2(N_IN) | Source select, one field per capture channel |
| chan_en | input | 4 | Enable per capture channel |
| sw_zero | input | 1 | Software zeroing strobe |
| ext_zero_in | input | 1 | External zeroing pulse |
| zero_out | output | 1 | Zeroing pulse for a second unit |
| rd_en | input | 1 | Read strobe, removes the oldest word |
| rd_data | output | 32 | Oldest stored word, or 0 when empty |
| fifo_empty | output | 1 | Buffer holds no words |
| fifo_full | output | 1 | Buffer holds 64 words |
| overflow | output | 1 | Sticky flag: an edge was dropped |

## Verification
The assertions check the following on every cycle:
- the count steps by one and wraps at its limit;
- either zeroing source leaves a zero count, an empty buffer and a clear overflow flag;
- zero_out starts only after a software strobe;
- overflow stays set and the full and empty flags never hold together.

The stamps and tags inside stored words can only be shown by the bench's scenarios, which compare every cycle against a queue-based model. The same holds for the ascending order of same-cycle captures, which channels survive a partial overflow, and the effect of a read that meets an empty buffer.

// File: rtl/tsc_pkg.sv
// Shared constants and types for the timestamp capture block.
// Assumes exactly four capture channels, tagged by a 2-bit index.
package tsc_pkg;
    localparam int TAG_W   = 2;
    localparam int NUM_CH  = 1 << TAG_W;
    localparam int STAMP_W = 30;
    localparam int WORD_W  = TAG_W + STAMP_W;

    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [WORD_W-1:0]  word_t;
endpackage

// File: rtl/tsc_counter.sv
// Free-running stamp counter with a wrap limit and a synchronous zero.
// Assumes CNT_MAX fits in the stamp width; zero has priority over counting.
module tsc_counter
    import tsc_pkg::*;
#(
    parameter stamp_t CNT_MAX = '1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   zero,
    output stamp_t count
);

    // Advance the count, wrapping after CNT_MAX, or clear it on zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (zero || count == CNT_MAX) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tsc_route.sv
// Routes one of N_IN inputs to each capture channel and detects rising edges.
// Assumes N_IN is a power of two so every select value names an input;
// inputs are already synchronous to clk.
module tsc_route
    import tsc_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int SELW = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        sig_in,
    input  logic [NUM_CH*SELW-1:0] route_sel,
    input  logic [NUM_CH-1:0]      chan_en,
    output logic [NUM_CH-1:0]      hit
);

    logic [N_IN-1:0] prev_q;
    logic [N_IN-1:0] rise;

    // Remember last cycle's inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sig_in;
        end
    end

    assign rise = sig_in & ~prev_q;

    // One selector and enable gate per capture channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign hit[g] = chan_en[g] & rise[route_sel[g*SELW +: SELW]];
    end

endmodule

// File: rtl/tsc_zero_ctl.sv
// Merges the two zeroing sources and stretches a software strobe into an
// outgoing zeroing pulse of PULSE_W cycles. A repeated strobe restarts it.
module tsc_zero_ctl #(
    parameter int PULSE_W = 2,
    localparam int PW = $clog2(PULSE_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_zero,
    input  logic ext_zero,
    output logic zero,
    output logic zero_out
);

    logic [PW-1:0] left_q;

    assign zero = sw_zero | ext_zero;

    // Count down the remaining cycles of the outgoing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (sw_zero) begin
            left_q <= PW'(PULSE_W);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero_out = (left_q != '0);

endmodule

// File: rtl/tsc_fifo.sv
// Capture buffer taking up to NUM_CH writes per cycle, stored in ascending
// channel order, with a single read strobe and a show-ahead read port.
// Assumes DEPTH is a power of two larger than NUM_CH. Space is judged on the
// level before this cycle's read. clear empties the buffer and the overflow flag.
module tsc_fifo
    import tsc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [NUM_CH-1:0] hit,
    input  stamp_t            stamp,
    input  logic              rd_en,
    output word_t             rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow
);

    word_t             mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     level, space, n_acc, below;
    logic [CW-1:0]     rank [NUM_CH];
    logic [NUM_CH-1:0] take;
    logic              pop, drop;

    assign empty = (level == '0);
    assign full  = (level == CW'(DEPTH));
    assign pop   = rd_en & ~empty;

    // Rank each capture among this cycle's hits and accept those that fit.
    always_comb begin
        space = CW'(DEPTH) - level;
        below = '0;
        n_acc = '0;
        drop  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            rank[i] = below;
            take[i] = hit[i] && (below < space);
            if (hit[i] && !(below < space)) begin
                drop = 1'b1;
            end
            if (hit[i]) begin
                below = below + 1'b1;
            end
            n_acc = n_acc + CW'(take[i]);
        end
    end

    // Pointer, level and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + n_acc[AW-1:0];
            rd_ptr <= rd_ptr + AW'(pop);
            level  <= level + n_acc - CW'(pop);
            if (drop) begin
                overflow <= 1'b1;
            end
        end
    end

    // Store accepted words at consecutive slots after the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (take[i]) begin
                mem[wr_ptr + rank[i][AW-1:0]] <= {TAG_W'(i), stamp};
            end
        end
    end

    assign rd_data = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/tsc_capture.sv
// Top of the timestamp capture block: counter, channel routing, zeroing
// control and capture buffer. All inputs are synchronous to clk; the reset
// is synchronous and active low.
module tsc_capture
    import tsc_pkg::*;
#(
    parameter int     N_IN    = 8,
    parameter int     DEPTH   = 64,
    parameter stamp_t CNT_MAX = 30'h3FFF_FFFF,
    parameter int     PULSE_W = 2,
    localparam int    SELW    = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        sig_in,
    input  logic [NUM_CH*SELW-1:0] route_sel,
    input  logic [NUM_CH-1:0]      chan_en,
    input  logic                   sw_zero,
    input  logic                   ext_zero_in,
    output logic                   zero_out,
    input  logic                   rd_en,
    output logic [WORD_W-1:0]      rd_data,
    output logic                   fifo_empty,
    output logic                   fifo_full,
    output logic                   overflow
);

    logic              zero;
    stamp_t            ts_now;
    logic [NUM_CH-1:0] hit;

    tsc_zero_ctl #(.PULSE_W(PULSE_W)) i_zero (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_zero  (sw_zero),
        .ext_zero (ext_zero_in),
        .zero     (zero),
        .zero_out (zero_out)
    );

    tsc_counter #(.CNT_MAX(CNT_MAX)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .zero  (zero),
        .count (ts_now)
    );

    tsc_route #(.N_IN(N_IN)) i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_in    (sig_in),
        .route_sel (route_sel),
        .chan_en   (chan_en),
        .hit       (hit)
    );

    tsc_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (zero),
        .hit      (hit),
        .stamp    (ts_now),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .overflow (overflow)
    );

endmodule

// File: rtl/tsc_capture_chk.sv
// Property checker for tsc_capture, attached to every instance by bind.
module tsc_capture_chk
    import tsc_pkg::*;
#(
    parameter stamp_t CNT_MAX = 30'h3FFF_FFFF
) (
    input logic   clk,
    input logic   rst_n,
    input logic   sw_zero,
    input logic   ext_zero_in,
    input logic   rd_en,
    input logic   zero_out,
    input logic   fifo_empty,
    input logic   fifo_full,
    input logic   overflow,
    input stamp_t ts_now
);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_zero && !ext_zero_in && ts_now != CNT_MAX) |=> ts_now == $past(ts_now) + 1'b1);

    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_zero && !ext_zero_in && ts_now == CNT_MAX) |=> ts_now == '0);

    assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !rd_en && !sw_zero && !ext_zero_in) |=> fifo_full);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !sw_zero && !ext_zero_in) |=> overflow);

    assert_sw_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_zero |=> (ts_now == '0 && fifo_empty && !overflow));

    assert_ext_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_zero_in |=> (ts_now == '0 && fifo_empty && !overflow));

    assert_pulse_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_zero |=> zero_out);

    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_zero && !zero_out) |=> !zero_out);

endmodule

bind tsc_capture tsc_capture_chk #(.CNT_MAX(CNT_MAX)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_zero     (sw_zero),
    .ext_zero_in (ext_zero_in),
    .rd_en       (rd_en),
    .zero_out    (zero_out),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .overflow    (overflow),
    .ts_now      (ts_now)
);

// File: tb/test_tsc_capture.sv
`timescale 1ns/100ps
module test_tsc_capture;
    localparam int          N_IN  = 8;
    localparam int          DEPTH = 64;
    localparam logic [29:0] CMAX  = 30'd500;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  sig_in = '0;
    logic [11:0] route_sel = '0;
    logic [3:0]  chan_en = '0;
    logic        sw_zero = 1'b0, ext_zero_in = 1'b0, rd_en = 1'b0;
    logic        zero_out, fifo_empty, fifo_full, overflow;
    logic [31:0] rd_data;

    tsc_capture #(.N_IN(N_IN), .DEPTH(DEPTH), .CNT_MAX(CMAX), .PULSE_W(2)) i_tsc_capture (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .route_sel(route_sel),
        .chan_en(chan_en), .sw_zero(sw_zero), .ext_zero_in(ext_zero_in),
        .zero_out(zero_out), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    // Behavioural reference: queue of words, count, flag and pulse length.
    logic [31:0] q[$];
    logic [29:0] m_cnt = '0;
    bit          m_ovf = 1'b0;
    int          m_pc = 0;
    logic [7:0]  m_prev = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_cnt = '0; m_ovf = 1'b0; m_pc = 0; m_prev = '0;
        end else begin
            if (sw_zero || ext_zero_in) begin
                q.delete(); m_ovf = 1'b0; m_cnt = '0;
            end else begin
                int free;
                free = DEPTH - q.size();
                if (rd_en && q.size() > 0) void'(q.pop_front());
                for (int k = 0; k < 4; k++) begin
                    int s;
                    s = int'(route_sel[k*3 +: 3]);
                    if (chan_en[k] && sig_in[s] && !m_prev[s]) begin
                        if (free > 0) begin
                            q.push_back({k[1:0], m_cnt});
                            free--;
                        end else begin
                            m_ovf = 1'b1;
                        end
                    end
                end
                m_cnt = (m_cnt == CMAX) ? 30'd0 : m_cnt + 30'd1;
            end
            if (sw_zero) m_pc = 2;
            else if (m_pc > 0) m_pc--;
            m_prev = sig_in;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3/R4/R5 rd_data", rd_data, (q.size() == 0) ? 32'd0 : q[0]);
            chk("R6 fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
            chk("R6 fifo_full", 32'(fifo_full), 32'(q.size() == DEPTH));
            chk("R7 overflow", 32'(overflow), 32'(m_ovf));
            chk("R10 zero_out", 32'(zero_out), 32'(m_pc != 0));
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drain();
        rd_en = 1'b1;
        step(DEPTH + 4);
        rd_en = 1'b0;
    endtask

    initial begin
        step(3);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        chk("R11 empty after reset", 32'(fifo_empty), 32'd1);
        chk("R11 overflow after reset", 32'(overflow), 32'd0);
        chk("R11 zero_out after reset", 32'(zero_out), 32'd0);
        step(1);

        // R2/R3: ch0<-in2, ch1<-in5, ch2<-in5, ch3<-in7, ch3 disabled
        route_sel = {3'd7, 3'd5, 3'd5, 3'd2};
        chan_en = 4'b0111;
        sig_in = 8'h04; step(1); sig_in = 8'h00; step(3);
        sig_in = 8'h20; step(1); sig_in = 8'h00; step(2);
        sig_in = 8'h24; step(1); sig_in = 8'h00; step(2);   // R4: same-cycle captures
        drain();
        // R2: a disabled channel stores nothing
        sig_in = 8'h80; step(1); sig_in = 8'h00; step(1);
        @(negedge clk);
        chk("R2 disabled channel leaves buffer empty", 32'(fifo_empty), 32'd1);
        step(1);
        // R5: reading an empty buffer has no effect
        rd_en = 1'b1; step(2); rd_en = 1'b0;

        // R7: all four channels on in0, fill past 64 words
        route_sel = '0; chan_en = 4'hF;
        for (int e = 0; e < 17; e++) begin
            sig_in = 8'h01; step(1); sig_in = 8'h00; step(1);
        end
        @(negedge clk);
        chk("R6 full after filling", 32'(fifo_full), 32'd1);
        chk("R7 overflow after dropped edges", 32'(overflow), 32'd1);
        step(1);
        // R6: read and capture in the same cycle while full
        rd_en = 1'b1; sig_in = 8'h01; step(1); rd_en = 1'b0; sig_in = 8'h00; step(1);
        drain();

        // R8/R10: software zero with data present
        sig_in = 8'h01; step(1); sig_in = 8'h00; step(1);
        sw_zero = 1'b1; sig_in = 8'h01; step(1); sw_zero = 1'b0; sig_in = 8'h00;
        @(negedge clk);
        chk("R8 buffer emptied by software zero", 32'(fifo_empty), 32'd1);
        chk("R10 zero_out first cycle", 32'(zero_out), 32'd1);
        step(1);
        @(negedge clk);
        chk("R10 zero_out second cycle", 32'(zero_out), 32'd1);
        step(1);
        @(negedge clk);
        chk("R10 zero_out ends", 32'(zero_out), 32'd0);

        // R1: count after zero and wrap, 700 cycles -> 700 mod 501 = 199
        sw_zero = 1'b1; step(1); sw_zero = 1'b0;
        route_sel = {3'd6, 3'd6, 3'd6, 3'd6}; chan_en = 4'b0100;
        step(700);
        sig_in = 8'h40; step(1); sig_in = 8'h00;
        @(negedge clk);
        chk("R1/R3 stamp after wrap", rd_data, {2'd2, 30'd199});
        step(1);

        // R9: external zero clears overflow and data, no outgoing pulse
        route_sel = '0; chan_en = 4'hF;
        for (int e = 0; e < 17; e++) begin
            sig_in = 8'h01; step(1); sig_in = 8'h00; step(1);
        end
        ext_zero_in = 1'b1; step(1); ext_zero_in = 1'b0;
        @(negedge clk);
        chk("R9 overflow cleared by external zero", 32'(overflow), 32'd0);
        chk("R9 buffer emptied by external zero", 32'(fifo_empty), 32'd1);
        chk("R10 no pulse from external zero", 32'(zero_out), 32'd0);
        step(1);

        // Mixed random traffic, compared every cycle
        for (int c = 0; c < 4000; c++) begin
            sig_in = 8'($urandom);
            rd_en = ($urandom % 4) == 0;
            sw_zero = ($urandom % 300) == 0;
            ext_zero_in = ($urandom % 400) == 0;
            if ((c % 500) == 0) begin
                route_sel = 12'($urandom);
                chan_en = 4'($urandom);
            end
            step(1);
        end
        sig_in = '0; rd_en = 1'b0; sw_zero = 1'b0; ext_zero_in = 1'b0;
        drain();
        step(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule